// File: doc/BRIEF.md
# Voice Key Controller

This block is the host-facing register front end of an eight-voice sound engine. A host writes a byte to one of 128 register slots through a synchronous index/data port and reads any slot back one cycle after a read strobe. Most slots are plain storage for the rest of the engine. A handful have side effects. The key-on and key-off slots produce per-voice start and release pulses. The control-flag slot drives global mute, echo-write enable and the noise clock rate, and can trigger a soft reset. The echo-delay slot supplies a 4-bit delay code. The voice-end slot collects end-of-sample flags reported by the voices.

A key-on request for a voice whose key-off bit is still set does not start that voice. The request is held pending and fires only when a later key-off write clears that bit. The end-flag slot cannot be loaded by the host: any host write to it clears it.

Top module: `voice_keyctl`

## Requirements
- R1: After reset every slot reads 0x00, except the control-flag slot (index 0x2F), which reads 0x60. After reset `mute` is 1, `echo_we` is 0, and all pulses are 0.
- R2: A write to the key-on slot (index 0x0F) gives a one-cycle `voice_start` pulse, in the cycle after the write, for each voice whose data bit is 1 and whose stored key-off bit is 0. The end flag of each started voice is cleared.
- R3: A key-on bit written while the voice's key-off bit is 1 starts nothing. It is latched as pending. A later key-off write with that voice's bit at 0 starts the voice and clears the pending latch. A soft reset also clears the pending latch.
- R4: A write to the key-off slot (index 0x1F) releases each voice that has its data bit at 1 and is currently keyed, and also clears that voice's bit in the key-on slot. The written byte then reads back from the key-off slot. A set bit for a voice that is not keyed gives no release.
- R5: Writing the control-flag slot with bit 7 set does five things. It gives a one-cycle `soft_rst` pulse. It releases every keyed voice. It stores 0x60 plus the low 5 data bits. It clears the key-on, key-off, end-flag and pending state. It drives `mute`=1 and `echo_we`=0.
- R6: Writing the control-flag slot with bit 7 clear stores the byte. `mute` then follows bit 6, `echo_we` follows the inverse of bit 5, and `noise_rate` follows bits 4..0.
- R7: The end-flag slot (index 0x3F) sets bit v when `voice_done[v]` is 1. A host write to that slot stores 0 whatever the data.
- R8: Only the low 4 bits of the echo-delay slot (index 0x4F) drive `echo_delay`. The full byte reads back.
- R9: Writes with index 0x80 or above change nothing. Reads use only the low 7 index bits. Read data appears one cycle after `host_rd`.
- R10: Start and release outputs are single-cycle pulses, one bit per voice. A voice never sees start and release in the same cycle; release wins.
- R11: Every other slot stores the written byte and reads it back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_idx | input | 8 | Register index |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Read data, valid the cycle after `host_rd` |
| voice_done | input | 8 | Per-voice end-of-sample reports |
| voice_start | output | 8 | Per-voice start pulses |
| voice_release | output | 8 | Per-voice release pulses |
| soft_rst | output | 1 | Soft-reset pulse |
| mute | output | 1 | Global mute |
| echo_we | output | 1 | Echo buffer write enable |
| noise_rate | output | 5 | Noise clock rate select |
| echo_delay | output | 4 | Echo delay code |

## Verification
Every result of a host cycle is due exactly one clock after the rising edge that samples the strobe. This covers the start and release pulses, `soft_rst`, read data, and the new levels of `mute`, `echo_we`, `noise_rate` and `echo_delay`. The driver applies each cycle's inputs on the falling edge and queues the expected values for that cycle. The monitor pops one queued item 2 ns after every rising edge, so each comparison lands in the single cycle where the result is due. Reads that share a cycle with a write are expected to return the value held before that write.

// File: rtl/keyctl_pkg.sv
package keyctl_pkg;
   // control-flag bit positions
   localparam int unsigned FLAG_SRST    = 7;
   localparam int unsigned FLAG_MUTE    = 6;
   localparam int unsigned FLAG_ECHOOFF = 5;
   localparam int unsigned NOISE_W      = 5;
   localparam int unsigned DELAY_W      = 4;
   localparam int unsigned SLOT_W       = 7;

   // slot indexes with side effects
   localparam logic [SLOT_W-1:0] IDX_START = 7'h0F;
   localparam logic [SLOT_W-1:0] IDX_STOP  = 7'h1F;
   localparam logic [SLOT_W-1:0] IDX_FLAG  = 7'h2F;
   localparam logic [SLOT_W-1:0] IDX_END   = 7'h3F;
   localparam logic [SLOT_W-1:0] IDX_DELAY = 7'h4F;

   typedef struct packed {
      logic start;
      logic stop;
      logic flag;
      logic endf;
      logic delay;
   } slot_hit_t;
endpackage

// File: rtl/keyctl_regfile.sv
module keyctl_regfile #(
   parameter int unsigned AW = 7,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rword
);
   localparam int unsigned NREG = 1 << AW;

   logic [DW-1:0] mem [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)
            mem[i] <= '0;
         else if (we && waddr == AW'(i))
            mem[i] <= wdata;
      end
   end

   assign rword = mem[raddr];
endmodule

// File: rtl/keyctl_ctrl.sv
module keyctl_ctrl
   import keyctl_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_flag,
   input  logic               wr_delay,
   input  logic [DW-1:0]      wdata,
   output logic               srst_now,
   output logic [DW-1:0]      flag_q,
   output logic               soft_rst_o,
   output logic               mute_o,
   output logic               echo_we_o,
   output logic [NOISE_W-1:0] noise_o,
   output logic [DELAY_W-1:0] delay_o
);
   localparam logic [DW-1:0] FLAG_RST = DW'((1 << FLAG_MUTE) | (1 << FLAG_ECHOOFF));

   logic [DW-1:0] flag_soft;

   assign srst_now = wr_flag & wdata[FLAG_SRST];

   always_comb begin
      flag_soft = FLAG_RST;
      flag_soft[NOISE_W-1:0] = wdata[NOISE_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q     <= FLAG_RST;
         delay_o    <= '0;
         soft_rst_o <= 1'b0;
      end else begin
         soft_rst_o <= srst_now;
         if (wr_flag)
            flag_q <= srst_now ? flag_soft : wdata;
         if (wr_delay)
            delay_o <= wdata[DELAY_W-1:0];
      end
   end

   assign mute_o    = flag_q[FLAG_MUTE];
   assign echo_we_o = ~flag_q[FLAG_ECHOOFF];
   assign noise_o   = flag_q[NOISE_W-1:0];

   // R5: a soft reset leaves the outputs muted with echo writes off
   assert_softrst_mutes_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |-> (mute_o && !echo_we_o));
endmodule

// File: rtl/keyctl_voice_seq.sv
module keyctl_voice_seq #(
   parameter int unsigned VOICES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic              wr_stop,
   input  logic              wr_end,
   input  logic              srst,
   input  logic [VOICES-1:0] wdata,
   input  logic [VOICES-1:0] done,
   output logic [VOICES-1:0] start_o,
   output logic [VOICES-1:0] release_o,
   output logic [VOICES-1:0] kon_q,
   output logic [VOICES-1:0] koff_q,
   output logic [VOICES-1:0] end_q
);
   logic [VOICES-1:0] keyed_q, pend_q;
   logic [VOICES-1:0] fire, rel;
   logic [VOICES-1:0] keyed_d, pend_d, kon_d, koff_d, end_d;

   always_comb begin
      fire    = '0;
      rel     = '0;
      keyed_d = keyed_q;
      pend_d  = pend_q;
      kon_d   = kon_q;
      koff_d  = koff_q;
      end_d   = end_q | done;
      if (srst) begin
         rel     = keyed_q;
         keyed_d = '0;
         pend_d  = '0;
         kon_d   = '0;
         koff_d  = '0;
         end_d   = '0;
      end else if (wr_start) begin
         fire    = wdata & ~koff_q;
         pend_d  = (pend_q | (wdata & koff_q)) & ~fire;
         keyed_d = keyed_q | fire;
         kon_d   = wdata;
      end else if (wr_stop) begin
         rel     = wdata & keyed_q;
         fire    = ~wdata & pend_q;
         keyed_d = (keyed_q & ~rel) | fire;
         pend_d  = pend_q & ~rel & ~fire;
         kon_d   = kon_q & ~rel;
         koff_d  = wdata;
      end else if (wr_end) begin
         end_d   = '0;
      end
      end_d = end_d & ~fire;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         keyed_q   <= '0;
         pend_q    <= '0;
         kon_q     <= '0;
         koff_q    <= '0;
         end_q     <= '0;
         start_o   <= '0;
         release_o <= '0;
      end else begin
         keyed_q   <= keyed_d;
         pend_q    <= pend_d;
         kon_q     <= kon_d;
         koff_q    <= koff_d;
         end_q     <= end_d;
         start_o   <= fire & ~rel;
         release_o <= rel;
      end
   end

   // R10: start and release never coincide on one voice
   assert_pulse_disjoint_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (start_o & release_o) == '0);
   // R4: only voices keyed in the previous cycle are released
   assert_release_keyed_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (release_o & ~$past(keyed_q)) == '0);
   // R2: a started voice shows a clear end flag
   assert_start_clears_end_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (start_o & end_q) == '0);
   // R3: a pending start only exists behind a set key-off bit
   assert_pend_behind_koff_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q & ~koff_q) == '0);
endmodule

// File: rtl/voice_keyctl.sv
module voice_keyctl
   import keyctl_pkg::*;
#(
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned DW     = 8,
   parameter int unsigned VOICES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IDX_W-1:0]   host_idx,
   input  logic [DW-1:0]      host_wdata,
   input  logic               host_wr,
   input  logic               host_rd,
   output logic [DW-1:0]      host_rdata,
   input  logic [VOICES-1:0]  voice_done,
   output logic [VOICES-1:0]  voice_start,
   output logic [VOICES-1:0]  voice_release,
   output logic               soft_rst,
   output logic               mute,
   output logic               echo_we,
   output logic [NOISE_W-1:0] noise_rate,
   output logic [DELAY_W-1:0] echo_delay
);
   localparam int unsigned AW = IDX_W - 1;

   if (AW < SLOT_W) begin : g_bad_idx
      $error("IDX_W must leave room for 7 slot bits");
   end
   if (DW < 8) begin : g_bad_dw
      $error("DW must hold the control-flag fields");
   end
   if (VOICES > DW) begin : g_bad_voices
      $error("VOICES must fit in one data word");
   end

   logic          in_range, wr_ok;
   logic [AW-1:0] slot;
   slot_hit_t     hit;
   logic          srst_now;
   logic [DW-1:0] rf_word, flag_q, rd_mux;
   logic [VOICES-1:0] kon_q, koff_q, end_q;

   assign in_range = ~host_idx[IDX_W-1];
   assign slot     = host_idx[AW-1:0];
   assign wr_ok    = host_wr & in_range;

   always_comb begin
      hit.start = wr_ok && slot == AW'(IDX_START);
      hit.stop  = wr_ok && slot == AW'(IDX_STOP);
      hit.flag  = wr_ok && slot == AW'(IDX_FLAG);
      hit.endf  = wr_ok && slot == AW'(IDX_END);
      hit.delay = wr_ok && slot == AW'(IDX_DELAY);
   end

   keyctl_regfile #(.AW(AW), .DW(DW)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_ok),
      .waddr (slot),
      .wdata (host_wdata),
      .raddr (slot),
      .rword (rf_word)
   );

   keyctl_ctrl #(.DW(DW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_flag    (hit.flag),
      .wr_delay   (hit.delay),
      .wdata      (host_wdata),
      .srst_now   (srst_now),
      .flag_q     (flag_q),
      .soft_rst_o (soft_rst),
      .mute_o     (mute),
      .echo_we_o  (echo_we),
      .noise_o    (noise_rate),
      .delay_o    (echo_delay)
   );

   keyctl_voice_seq #(.VOICES(VOICES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_start  (hit.start),
      .wr_stop   (hit.stop),
      .wr_end    (hit.endf),
      .srst      (srst_now),
      .wdata     (host_wdata[VOICES-1:0]),
      .done      (voice_done),
      .start_o   (voice_start),
      .release_o (voice_release),
      .kon_q     (kon_q),
      .koff_q    (koff_q),
      .end_q     (end_q)
   );

   always_comb begin
      if (slot == AW'(IDX_START))
         rd_mux = DW'(kon_q);
      else if (slot == AW'(IDX_STOP))
         rd_mux = DW'(koff_q);
      else if (slot == AW'(IDX_FLAG))
         rd_mux = flag_q;
      else if (slot == AW'(IDX_END))
         rd_mux = DW'(end_q);
      else
         rd_mux = rf_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         host_rdata <= '0;
      else if (host_rd)
         host_rdata <= rd_mux;
   end

   // R5: the soft-reset pulse always comes with an empty key-off register
   assert_softrst_clears_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> (koff_q == '0 && kon_q == '0 && end_q == '0));
endmodule

// File: tb/sim_voice_keyctl.sv
module sim_voice_keyctl;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n;
   logic [7:0] idx, wd, done;
   logic       wr, rd;
   logic [7:0] rdata, vstart, vrel;
   logic       srst, mute, ewe;
   logic [4:0] noise;
   logic [3:0] dly;

   voice_keyctl u0 (
      .clk (clk), .rst_n (rst_n), .host_idx (idx), .host_wdata (wd),
      .host_wr (wr), .host_rd (rd), .host_rdata (rdata), .voice_done (done),
      .voice_start (vstart), .voice_release (vrel), .soft_rst (srst),
      .mute (mute), .echo_we (ewe), .noise_rate (noise), .echo_delay (dly)
   );

   typedef struct {
      logic [7:0] st, rl, rdv;
      logic       sr, chk, mu, ew;
      logic [4:0] nz;
      logic [3:0] dl;
      string      tag;
   } exp_t;

   exp_t q[$];
   int vectors = 0, miscompares = 0;
   bit ended = 0;

   // reference state, built from the requirements
   logic [7:0] m_kon, m_koff, m_end, m_keyed, m_pend, m_flag;
   logic [3:0] m_dly;
   logic [7:0] m_mem [128];

   function automatic logic [7:0] mread(input logic [7:0] i);
      case (i[6:0])
         7'h0F: return m_kon;
         7'h1F: return m_koff;
         7'h2F: return m_flag;
         7'h3F: return m_end;
         default: return m_mem[i[6:0]];
      endcase
   endfunction

   task automatic step(input bit w, input bit r, input logic [7:0] i,
                       input logic [7:0] d, input logic [7:0] dn, input string tag);
      exp_t e;
      logic [7:0] fire, rel, end_n;
      @(negedge clk);
      wr = w; rd = r; idx = i; wd = d; done = dn;
      e.chk = r; e.rdv = mread(i); e.tag = tag; e.sr = 1'b0;
      fire = '0; rel = '0; end_n = m_end | dn;
      if (w && !i[7]) begin
         m_mem[i[6:0]] = d;
         case (i[6:0])
            7'h2F: if (d[7]) begin
                      e.sr = 1'b1; rel = m_keyed; m_keyed = '0; m_pend = '0;
                      m_kon = '0; m_koff = '0; end_n = '0;
                      m_flag = {3'b011, d[4:0]};
                   end else m_flag = d;
            7'h0F: begin
                      fire = d & ~m_koff;
                      m_pend = (m_pend | (d & m_koff)) & ~fire;
                      m_keyed = m_keyed | fire; m_kon = d;
                   end
            7'h1F: begin
                      rel = d & m_keyed; fire = ~d & m_pend;
                      m_keyed = (m_keyed & ~rel) | fire;
                      m_pend = m_pend & ~rel & ~fire;
                      m_kon = m_kon & ~rel; m_koff = d;
                   end
            7'h3F: end_n = '0;
            7'h4F: m_dly = d[3:0];
            default: ;
         endcase
      end
      m_end = end_n & ~fire;
      e.st = fire & ~rel; e.rl = rel;
      e.mu = m_flag[6]; e.ew = ~m_flag[5]; e.nz = m_flag[4:0]; e.dl = m_dly;
      q.push_back(e);
   endtask

   task automatic cmp(input string f, input logic [7:0] act, input logic [7:0] exp,
                      input string tag, inout bit bad);
      if (act !== exp) begin
         $display("FAIL %s %s: actual %h expected %h", tag, f, act, exp);
         bad = 1'b1;
      end
   endtask

   // monitor: one queued item per cycle, sampled after the rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            bit bad;
            e = q.pop_front();
            bad = 1'b0;
            vectors++;
            cmp("start", vstart, e.st, e.tag, bad);
            cmp("release", vrel, e.rl, e.tag, bad);
            cmp("soft_rst", {7'd0, srst}, {7'd0, e.sr}, e.tag, bad);
            cmp("mute", {7'd0, mute}, {7'd0, e.mu}, e.tag, bad);
            cmp("echo_we", {7'd0, ewe}, {7'd0, e.ew}, e.tag, bad);
            cmp("noise", {3'd0, noise}, {3'd0, e.nz}, e.tag, bad);
            cmp("delay", {4'd0, dly}, {4'd0, e.dl}, e.tag, bad);
            cmp("overlap R10", vstart & vrel, 8'h00, e.tag, bad);
            if (e.chk) cmp("rdata", rdata, e.rdv, e.tag, bad);
            if (bad) miscompares++;
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!ended) begin
         ended = 1;
         miscompares++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr = 0; rd = 0; idx = 0; wd = 0; done = 0;
      m_kon = 0; m_koff = 0; m_end = 0; m_keyed = 0; m_pend = 0;
      m_flag = 8'h60; m_dly = 0;
      for (int k = 0; k < 128; k++) m_mem[k] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      step(0, 1, 8'h2F, 0, 0, "R1 flag reset");
      step(0, 1, 8'h05, 0, 0, "R1 plain reset");
      step(0, 1, 8'h0F, 0, 0, "R1 key-on reset");
      step(0, 1, 8'h00, 0, 0, "R1 read settle");
      // R11 plain storage, R9 index handling
      step(1, 0, 8'h05, 8'hA5, 0, "R11 write plain");
      step(0, 1, 8'h05, 0, 0, "R11 readback");
      step(0, 1, 8'h85, 0, 0, "R9 read masks index");
      step(1, 0, 8'h85, 8'h11, 0, "R9 high write");
      step(0, 1, 8'h05, 0, 0, "R9 high write ignored");
      step(1, 0, 8'hAF, 8'h85, 0, "R9 high flag write no effect");
      step(0, 1, 8'h2F, 0, 0, "R9 flag unchanged");
      // R2 key-on, R7 end flags
      step(1, 0, 8'h0F, 8'h03, 0, "R2 key-on v0 v1");
      step(0, 0, 8'h00, 0, 8'h07, "R7 voices report end");
      step(0, 1, 8'h3F, 0, 0, "R7 end readback");
      step(1, 0, 8'h0F, 8'h04, 0, "R2 key-on v2 clears end");
      step(0, 1, 8'h3F, 0, 0, "R2 end bit cleared");
      step(1, 0, 8'h3F, 8'hFF, 0, "R7 host end write");
      step(0, 1, 8'h3F, 0, 0, "R7 end reads zero");
      // R4 key-off
      step(1, 0, 8'h1F, 8'h01, 0, "R4 release v0");
      step(0, 1, 8'h1F, 0, 0, "R4 key-off readback");
      step(1, 0, 8'h1F, 8'h81, 0, "R4 unkeyed set bit no release");
      // R3 deferred start
      step(1, 0, 8'h0F, 8'h81, 0, "R3 key-on held pending");
      step(1, 0, 8'h1F, 8'h01, 0, "R3 v7 fires on clear");
      step(1, 0, 8'h1F, 8'h00, 0, "R3 v0 fires on clear");
      step(1, 0, 8'h1F, 8'h00, 0, "R3 no second start");
      step(0, 1, 8'h0F, 0, 0, "R4 key-on slot after release");
      // R6 flag decode
      step(1, 0, 8'h2F, 8'h1A, 0, "R6 unmute echo on");
      step(1, 0, 8'h2F, 8'h3F, 0, "R6 echo off");
      step(0, 1, 8'h2F, 0, 0, "R6 flag readback");
      // R8 echo delay
      step(1, 0, 8'h4F, 8'hF7, 0, "R8 delay low bits");
      step(0, 1, 8'h4F, 0, 0, "R8 full byte readback");
      // R5 soft reset with voices keyed and one pending
      step(1, 0, 8'h1F, 8'h10, 0, "R5 setup key-off v4");
      step(1, 0, 8'h0F, 8'h12, 0, "R5 setup pending v4");
      step(1, 0, 8'h2F, 8'h85, 0, "R5 soft reset");
      step(0, 1, 8'h2F, 0, 0, "R10 soft_rst single cycle");
      step(0, 1, 8'h1F, 0, 0, "R5 key-off cleared");
      step(0, 1, 8'h0F, 0, 0, "R5 key-on cleared");
      step(1, 0, 8'h1F, 8'h00, 0, "R3 pending dropped by soft reset");
      step(0, 0, 8'h00, 0, 0, "R10 idle");
      wait (q.size() == 0);
      @(negedge clk);
      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule